// File: doc/BRIEF.md
# DMA Interrupt Control and Channel Start Gate

This block holds the interrupt control word of a seven-channel DMA controller and decides when each channel may begin a transfer. The control word packs per-channel completion-interrupt enables, a global enable, a bus error bit, sticky per-channel completion flags and a master flag. When the master flag goes from clear to set, the block sends a single-cycle interrupt pulse to the system interrupt controller. The pulse is sent only on that transition.

Software reaches the block through a simple register bus: a write port and a separate combinational read port. Each channel has a control register. Writing it with the start bit set launches the channel, provided that channel's bit in the enable register is also set. The launch is a one-cycle pulse to the transfer engine, which lives outside this block. When the engine finishes, it returns a one-cycle done pulse. That pulse clears the channel's start bit. If the channel's completion interrupt is enabled, the pulse also sets the channel's flag.

Top module: `dma_irq_ctl`

## Requirements
- R1: After synchronous reset, every register reads 0, and `irq` and `chan_start` are low.
- R2: A write to the interrupt control word (address 0x74) loads the bits in mask 0x00FF803F from `wdata`: bits 5:0, bit 15 (bus error), bits 22:16 (per-channel enables, channel n at bit 16+n) and bit 23 (global enable). Writing bit 31 has no effect.
- R3: Flags sit at bits 30:24, channel n at bit 24+n. On a write to 0x74, each flag whose written bit is 1 is cleared, and each flag whose written bit is 0 keeps its value. A write never sets a flag.
- R4: A done pulse on channel n sets flag 24+n only if enable bit 16+n is set. Whether or not the flag is set, the pulse clears bit 24 of channel n's control register.
- R5: Master flag bit 31 is set exactly when bit 15 is set, or when bit 23 is set and at least one flag is set. It is re-evaluated after every write and every done pulse.
- R6: `irq` is high for exactly one cycle, in the cycle after the update that takes bit 31 from 0 to 1. It stays low while bit 31 remains set.
- R7: A write to channel n's control register pulses `chan_start[n]` for one cycle, but only when the written bit 24 is 1 and bit 4n+3 of the enable register is 1.
- R8: Channel n's control register is at address 0x08+0x10n, the enable register at 0x70 and the interrupt control word at 0x74. All three read back on `rdata`, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Write address |
| wdata | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| rdata | output | 32 | Read data, combinational |
| chan_done | input | 7 | Per-channel transfer-complete pulses |
| chan_start | output | 7 | Per-channel transfer-start pulses |
| irq | output | 1 | One-cycle interrupt pulse to the system interrupt controller |

## Verification
The hardest case to reach is a master flag that is already set while a further cause arrives, because that cause must not produce a second interrupt. To get there, the stimulus sets the global and per-channel enables, lets one channel finish, and then has a second channel finish while the first flag is still pending. It then clears only one of the two flags. Only after that does it take the master flag low, then high again through a write that turns on the global enable while a flag is still held. A separate sequence checks that a done pulse from a channel whose completion interrupt is disabled leaves the flags unchanged, yet still clears that channel's start bit.

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl #(
  parameter int NCH = 7,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rdata,
  input  logic [NCH-1:0] chan_done,
  output logic [NCH-1:0] chan_start,
  output logic          irq
);
  localparam logic [31:0] WMASK    = 32'h00FF_803F;
  localparam logic [31:0] FLAGMASK = 32'h7F00_0000;
  localparam logic [AW-1:0] EN_ADDR  = AW'(8'h70);
  localparam logic [AW-1:0] ICR_ADDR = AW'(8'h74);
  localparam int CH_BASE = 8;
  localparam int CH_STEP = 16;

  logic [31:0] icr, en_r, icr_nx;
  logic [31:0] ctl [NCH];
  logic [NCH-1:0] hit, start_nx;

  always_comb begin
    icr_nx = icr;
    if (wr_en && addr == ICR_ADDR)
      icr_nx = (wdata & WMASK) | (icr & ~wdata & FLAGMASK);
    for (int n = 0; n < NCH; n++)
      if (chan_done[n] && icr_nx[16+n]) icr_nx[24+n] = 1'b1;
    icr_nx[31] = icr_nx[15] | (icr_nx[23] & |icr_nx[30:24]);
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit[n]      = wr_en && addr == AW'(CH_BASE + CH_STEP*n);
    assign start_nx[n] = hit[n] & wdata[24] & en_r[4*n+3];

    always_ff @(posedge clk) begin
      if (rst)               ctl[n] <= '0;
      else if (hit[n])       ctl[n] <= wdata;
      else if (chan_done[n]) ctl[n][24] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icr        <= '0;
      en_r       <= '0;
      irq        <= 1'b0;
      chan_start <= '0;
    end else begin
      icr        <= icr_nx;
      irq        <= icr_nx[31] & ~icr[31];
      chan_start <= start_nx;
      if (wr_en && addr == EN_ADDR) en_r <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_addr == ICR_ADDR) rdata = icr;
    if (rd_addr == EN_ADDR)  rdata = en_r;
    for (int n = 0; n < NCH; n++)
      if (rd_addr == AW'(CH_BASE + CH_STEP*n)) rdata = ctl[n];
  end
endmodule

module dma_irq_ctl_chk #(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           irq,
  input logic [NCH-1:0] chan_start,
  input logic [NCH-1:0] done,
  input logic [31:0]    icr,
  input logic [31:0]    en
);
  logic [6:0] dn;
  assign dn = 7'(done);

  a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    irq |-> $rose(icr[31]));
  a_r6_rise_gives_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(icr[31]) |-> irq);
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r4_flag_needs_done: assert property (@(posedge clk) disable iff (rst)
    (icr[30:24] & ~$past(icr[30:24]) & ~$past(dn)) == 7'd0);
  a_r5_master_has_cause: assert property (@(posedge clk) disable iff (rst)
    icr[31] |-> (icr[15] || (icr[23] && |icr[30:24])));
  a_r7_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_start));

  for (genvar n = 0; n < NCH; n++) begin : g_st
    a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
      chan_start[n] |-> $past(en[4*n+3]));
  end
endmodule

bind dma_irq_ctl dma_irq_ctl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .chan_start(chan_start),
  .done(chan_done), .icr(icr), .en(en_r)
);

// File: tb/dma_irq_ctl_test.sv
module dma_irq_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  rd_addr = 8'h74;
  logic [31:0] rdata;
  logic [6:0]  chan_done = '0;
  logic [6:0]  chan_start;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dma_irq_ctl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata), .chan_done(chan_done),
    .chan_start(chan_start), .irq(irq)
  );

  // fields: we, addr, wdata, done, exp_irq, exp_start, exp_icr
  localparam int NV = 16;
  localparam logic [87:0] VEC [NV] = '{
    {1'b1, 8'h70, 32'h0000_0008, 7'h00, 1'b0, 7'h00, 32'h0000_0000},
    {1'b1, 8'h08, 32'h0100_0000, 7'h00, 1'b0, 7'h01, 32'h0000_0000},
    {1'b1, 8'h18, 32'h0100_0000, 7'h00, 1'b0, 7'h00, 32'h0000_0000},
    {1'b1, 8'h74, 32'hFFFF_FFFF, 7'h00, 1'b1, 7'h00, 32'h80FF_803F},
    {1'b0, 8'h00, 32'h0000_0000, 7'h00, 1'b0, 7'h00, 32'h80FF_803F},
    {1'b1, 8'h74, 32'h0000_0000, 7'h00, 1'b0, 7'h00, 32'h0000_0000},
    {1'b1, 8'h74, 32'h0083_0000, 7'h00, 1'b0, 7'h00, 32'h0083_0000},
    {1'b0, 8'h00, 32'h0000_0000, 7'h01, 1'b1, 7'h00, 32'h8183_0000},
    {1'b0, 8'h00, 32'h0000_0000, 7'h02, 1'b0, 7'h00, 32'h8383_0000},
    {1'b0, 8'h00, 32'h0000_0000, 7'h04, 1'b0, 7'h00, 32'h8383_0000},
    {1'b1, 8'h74, 32'h0183_0000, 7'h00, 1'b0, 7'h00, 32'h8283_0000},
    {1'b1, 8'h74, 32'h0283_0000, 7'h00, 1'b0, 7'h00, 32'h0083_0000},
    {1'b1, 8'h74, 32'h8000_0000, 7'h00, 1'b0, 7'h00, 32'h0000_0000},
    {1'b1, 8'h74, 32'h0003_0000, 7'h00, 1'b0, 7'h00, 32'h0003_0000},
    {1'b0, 8'h00, 32'h0000_0000, 7'h01, 1'b0, 7'h00, 32'h0103_0000},
    {1'b1, 8'h74, 32'h0083_0000, 7'h00, 1'b1, 7'h00, 32'h8183_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] dn);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; chan_done = dn;
    @(posedge clk);
    #2;
    wr_en = 1'b0; chan_done = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 start", 32'(chan_start), 0);
    rd_addr = 8'h74; #1 chk("R1 icr", rdata, 0);
    rd_addr = 8'h70; #1 chk("R1 en", rdata, 0);
    rd_addr = 8'h08; #1 chk("R1 ctl0", rdata, 0);
    rd_addr = 8'h74;

    // table: R2 R3 R4 R5 R6 R7 R9-style cases
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][87], VEC[i][86:79], VEC[i][78:47], VEC[i][46:40]);
      chk($sformatf("R6 irq vec%0d", i), 32'(irq), 32'(VEC[i][39]));
      chk($sformatf("R7 start vec%0d", i), 32'(chan_start), 32'(VEC[i][38:32]));
      chk($sformatf("R2/R3/R5 icr vec%0d", i), rdata, VEC[i][31:0]);
    end

    // R6: no second irq while master held
    step(1'b0, 8'h00, 32'h0, 7'h00);
    chk("R6 no repeat", 32'(irq), 0);

    // R7 pulse is one cycle, R8 readback, R4 done clears start bit
    step(1'b1, 8'h08, 32'h0100_00AB, 7'h00);
    chk("R7 start ch0", 32'(chan_start), 32'h01);
    rd_addr = 8'h08; #1 chk("R8 ctl0", rdata, 32'h0100_00AB);
    step(1'b0, 8'h00, 32'h0, 7'h00);
    chk("R7 one cycle", 32'(chan_start), 0);
    step(1'b0, 8'h00, 32'h0, 7'h01);
    chk("R4 bit24 cleared", rdata, 32'h0000_00AB);

    // R7 channel 6 with enable bit 27
    step(1'b1, 8'h70, 32'h0800_0000, 7'h00);
    rd_addr = 8'h70; #1 chk("R8 en", rdata, 32'h0800_0000);
    step(1'b1, 8'h68, 32'h0000_0001, 7'h00);
    chk("R7 no start bit", 32'(chan_start), 0);
    step(1'b1, 8'h68, 32'h0100_0001, 7'h00);
    chk("R7 start ch6", 32'(chan_start), 32'h40);
    step(1'b1, 8'h08, 32'h0100_0000, 7'h00);
    chk("R7 ch0 disabled", 32'(chan_start), 0);
    rd_addr = 8'h68; #1 chk("R8 ctl6", rdata, 32'h0100_0001);

    // R8 unmapped read/write
    step(1'b1, 8'h0C, 32'hDEAD_BEEF, 7'h00);
    rd_addr = 8'h0C; #1 chk("R8 unmapped", rdata, 0);

    // R4 done with enable off: flags unchanged, bit24 still cleared
    rd_addr = 8'h74; #1 chk("R4 icr before", rdata, 32'h8183_0000);
    step(1'b0, 8'h00, 32'h0, 7'h40);
    chk("R4 disabled ch6 flag", rdata, 32'h8183_0000);
    rd_addr = 8'h68; #1 chk("R4 ch6 bit24", rdata, 32'h0000_0001);

    // R1 reset again clears all
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #2 rst = 1'b0;
    rd_addr = 8'h74; #1 chk("R1 icr after reset", rdata, 0);
    chk("R1 irq after reset", 32'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule